// File: doc/BRIEF.md
# Bit-Serial Video Memory Writer

This block sits between a processing core and a one-bit-wide video memory that is addressed per bit. The core announces each finished 32-bit result with a short ready strobe. The block watches for the end of that strobe and captures the result word. It then writes a fixed selection of the word's bits into the memory, one bit per clock, while a bit address counts upward.

The strobe is sampled in the system clock domain. A registered copy of the strobe is compared with its live value, so the strobe never acts as a clock. The word is seen as four bytes. From each byte only the six middle bits, positions 6 through 1, are written. The address counter keeps its value between bursts, so each burst continues where the last one ended.

Top module: `vram_bit_writer`

## Requirements
- R1: During and directly after a synchronous active-high reset, `busy` and `mem_we` are 0 and `mem_addr` is 0.
- R2: A burst starts only on a high-to-low change of `done_strobe`, seen when the registered strobe is 1 and the live strobe is 0 at a rising clock edge. `busy` and `mem_we` go high in the cycle after that edge. Holding the strobe high, or a rising change, starts nothing.
- R3: A burst drives `mem_we` high for exactly 24 consecutive cycles. `busy` equals `mem_we` throughout, and both return to 0 afterwards.
- R4: The write order is byte 3, 2, 1, 0. Within each byte the bit positions are 6, 5, 4, 3, 2, 1. In each write cycle `mem_bit` equals bit (byte*8 + position) of the captured word, so the first write carries word bit 30 and the last carries word bit 1.
- R5: `mem_addr` gives the address of the current write. It advances by exactly one after each write and holds while idle. It is not cleared between bursts, so a second burst begins at the first burst's start address plus 24.
- R6: The word is captured at the edge that starts the burst. Changes on `result_word` during the burst do not alter the bits written.
- R7: A falling strobe edge seen while `busy` is 1 is ignored. The running burst is unchanged and no second burst follows.
- R8: A reset asserted in the middle of a burst ends it. The next cycle shows `busy` = 0, `mem_we` = 0 and `mem_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| done_strobe | input | 1 | Result-ready strobe from the core, synchronous to clk |
| result_word | input | 32 | Result word from the core |
| mem_we | output | 1 | Video memory write enable, one cycle per bit |
| mem_bit | output | 1 | Data bit to write |
| mem_addr | output | ADDR_W (16) | Bit address of the current write |
| busy | output | 1 | High while a burst is in progress |

## Verification
The strobe is lowered at a falling clock edge. The rising edge that follows detects the change, so the first write (word bit 30 at the current address) must appear at the very next falling edge. The 23 writes that follow must appear at successive falling edges after it. The bench samples and checks outputs only at falling edges, in a counted loop that expects each result in exactly that cycle, and it keeps its own model of the address. Changes to the word, strobe pulses during a burst and resets are all applied at known loop iterations, so their effect or their absence is checked in a known cycle.

// File: rtl/vbw_pkg.sv
package vbw_pkg;

    localparam int WORD_W      = 32;
    localparam int BYTE_W      = 8;
    localparam int NUM_BYTES   = WORD_W / BYTE_W;
    localparam int BYTE_SEL_W  = $clog2(NUM_BYTES);
    localparam int BIT_SEL_W   = $clog2(BYTE_W);
    localparam int IDX_W       = BYTE_SEL_W + BIT_SEL_W;

    // window of bit positions written from each byte
    localparam int BIT_HI      = 6;
    localparam int BIT_LO      = 1;
    localparam int BITS_PER_BYTE = BIT_HI - BIT_LO + 1;
    localparam int BITS_PER_WORD = NUM_BYTES * BITS_PER_BYTE;

    typedef struct packed {
        logic [BYTE_SEL_W-1:0] byte_sel;
        logic [BIT_SEL_W-1:0]  bit_sel;
    } bit_pos_t;

    // position of the first bit of a burst
    function automatic bit_pos_t first_pos();
        bit_pos_t p;
        p.byte_sel = BYTE_SEL_W'(NUM_BYTES - 1);
        p.bit_sel  = BIT_SEL_W'(BIT_HI);
        return p;
    endfunction

    // flat bit index inside the word: byte*BYTE_W + bit
    function automatic logic [IDX_W-1:0] flat_index(bit_pos_t p);
        return {p.byte_sel, p.bit_sel};
    endfunction

endpackage

// File: rtl/vbw_edge_detect.sv
module vbw_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic strobe_in,
    output logic strobe_prev,
    output logic fall_seen
);
    always_ff @(posedge clk) begin
        if (rst) strobe_prev <= 1'b0;
        else     strobe_prev <= strobe_in;
    end

    assign fall_seen = strobe_prev & ~strobe_in;
endmodule

// File: rtl/vbw_sequencer.sv
module vbw_sequencer
    import vbw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output logic     busy,
    output bit_pos_t pos
);
    localparam logic [BIT_SEL_W-1:0]  LAST_BIT  = BIT_SEL_W'(BIT_LO);
    localparam logic [BYTE_SEL_W-1:0] LAST_BYTE = '0;

    logic last_bit_of_byte;
    logic last_of_word;

    assign last_bit_of_byte = (pos.bit_sel == LAST_BIT);
    assign last_of_word     = last_bit_of_byte && (pos.byte_sel == LAST_BYTE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            pos  <= first_pos();
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                pos  <= first_pos();
            end
        end else begin
            if (last_of_word) begin
                busy <= 1'b0;
                pos  <= first_pos();
            end else if (last_bit_of_byte) begin
                pos.byte_sel <= pos.byte_sel - 1'b1;
                pos.bit_sel  <= BIT_SEL_W'(BIT_HI);
            end else begin
                pos.bit_sel  <= pos.bit_sel - 1'b1;
            end
        end
    end
endmodule

// File: rtl/vbw_addr_counter.sv
module vbw_addr_counter #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (step) addr <= addr + 1'b1;
    end
endmodule

// File: rtl/vram_bit_writer.sv
module vram_bit_writer
    import vbw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done_strobe,
    input  logic [31:0]       result_word,
    output logic              mem_we,
    output logic              mem_bit,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy
);
    logic              strobe_prev;
    logic              fall_seen;
    logic              start;
    logic [WORD_W-1:0] word_q;
    bit_pos_t          pos;

    vbw_edge_detect u_edge (
        .clk         (clk),
        .rst         (rst),
        .strobe_in   (done_strobe),
        .strobe_prev (strobe_prev),
        .fall_seen   (fall_seen)
    );

    // edges during a burst are dropped
    assign start = fall_seen & ~busy;

    always_ff @(posedge clk) begin
        if (rst)        word_q <= '0;
        else if (start) word_q <= result_word;
    end

    vbw_sequencer u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .pos   (pos)
    );

    vbw_addr_counter #(.ADDR_W(ADDR_W)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .step (busy),
        .addr (mem_addr)
    );

    assign mem_we  = busy;
    assign mem_bit = word_q[flat_index(pos)];
endmodule

// File: rtl/vbw_checker.sv
module vbw_checker
    import vbw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              done_strobe,
    input logic              strobe_prev,
    input logic              busy,
    input logic              mem_we,
    input logic              mem_bit,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] word_q
);
    logic [7:0] we_run;

    always_ff @(posedge clk) begin
        if (rst)         we_run <= '0;
        else if (mem_we) we_run <= we_run + 1'b1;
        else             we_run <= '0;
    end

    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_we && we_run != 8'd0) |-> (we_run == 8'(BITS_PER_WORD)));

    // R2
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(busy)) |-> ($past(strobe_prev) && !$past(done_strobe)));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(mem_we)) |-> $stable(mem_addr));

    // R6
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && busy && $past(busy)) |-> $stable(word_q));

    // R4
    first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(mem_we)) |-> (mem_bit == word_q[30]));
endmodule

bind vram_bit_writer vbw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .done_strobe (done_strobe),
    .strobe_prev (strobe_prev),
    .busy        (busy),
    .mem_we      (mem_we),
    .mem_bit     (mem_bit),
    .mem_addr    (mem_addr),
    .word_q      (word_q)
);

// File: tb/vram_bit_writer_test.sv
module vram_bit_writer_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          done_strobe;
    logic [31:0]   result_word;
    logic          mem_we;
    logic          mem_bit;
    logic [AW-1:0] mem_addr;
    logic          busy;

    int n_tests = 0;
    int n_fail  = 0;
    logic [AW-1:0] exp_addr;

    always #5 clk = ~clk;

    vram_bit_writer #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .done_strobe(done_strobe),
        .result_word(result_word), .mem_we(mem_we), .mem_bit(mem_bit),
        .mem_addr(mem_addr), .busy(busy)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // raise the strobe for two cycles, then lower it at a falling edge
    task automatic pulse_strobe();
        @(negedge clk) done_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk) done_strobe = 1'b0;
    endtask

    // check a full burst of word w, starting at the next falling edge;
    // change_at: iteration at which result_word is overwritten (-1 none)
    // glitch_at: iteration at which a strobe pulse is started (-1 none)
    task automatic check_burst(input logic [31:0] w, input int change_at,
                               input int glitch_at, input string req);
        int k = 0;
        int fails_before = n_fail;
        for (int b = 3; b >= 0; b--) begin
            for (int p = 6; p >= 1; p--) begin
                @(negedge clk);
                if (k == change_at) result_word = ~w;
                if (k == glitch_at) done_strobe = 1'b1;
                if (k == glitch_at + 2) done_strobe = 1'b0;
                if (mem_we !== 1'b1 || busy !== 1'b1)
                    check({req, " R3"}, "we/busy in burst", {mem_we, busy}, 2'b11);
                if (mem_bit !== w[b*8+p])
                    check({req, " R4"}, $sformatf("bit b%0d p%0d", b, p), mem_bit, w[b*8+p]);
                if (mem_addr !== exp_addr)
                    check({req, " R5"}, "address", mem_addr, exp_addr);
                exp_addr = exp_addr + 1'b1;
                k++;
            end
        end
        n_tests++;
        if (n_fail != fails_before)
            $display("FAIL %s burst of %h: actual mismatches %0d expected 0",
                     req, w, n_fail - fails_before);
        @(negedge clk);
        check({req, " R3"}, "we after burst", mem_we, 0);
        check({req, " R3"}, "busy after burst", busy, 0);
        check({req, " R5"}, "address holds", mem_addr, exp_addr);
    endtask

    task automatic test_reset();
        rst = 1'b1; done_strobe = 1'b0; result_word = '0;
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", busy, 0);
        check("R1", "we in reset", mem_we, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "busy after reset", busy, 0);
        check("R1", "address after reset", mem_addr, 0);
        exp_addr = '0;
    endtask

    task automatic test_basic();
        result_word = 32'hA5C3_7E19;
        pulse_strobe();
        check_burst(32'hA5C3_7E19, -1, -1, "R2 R4");
        result_word = 32'h0000_0000;
        pulse_strobe();
        check_burst(32'h0000_0000, -1, -1, "R4");
        result_word = 32'hFFFF_FFFF;
        pulse_strobe();
        check_burst(32'hFFFF_FFFF, -1, -1, "R4");
    endtask

    task automatic test_rise_no_start();
        result_word = 32'h1357_9BDF;
        @(negedge clk) done_strobe = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R2", "we while strobe high", mem_we, 0);
        end
        done_strobe = 1'b0;
        check_burst(32'h1357_9BDF, -1, -1, "R2");
    endtask

    task automatic test_input_change();
        result_word = 32'h6C3A_94F1;
        pulse_strobe();
        check_burst(32'h6C3A_94F1, 0, -1, "R6");
    endtask

    task automatic test_busy_ignore();
        result_word = 32'h2468_ACE0;
        pulse_strobe();
        check_burst(32'h2468_ACE0, -1, 5, "R7");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R7", "no second burst", mem_we, 0);
        end
        check("R7", "address after ignored edge", mem_addr, exp_addr);
    endtask

    task automatic test_reset_mid();
        result_word = 32'hFEDC_BA98;
        pulse_strobe();
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8", "busy after mid reset", busy, 0);
        check("R8", "we after mid reset", mem_we, 0);
        check("R8", "address after mid reset", mem_addr, 0);
        exp_addr = '0;
        result_word = 32'h0F0F_F0F0;
        pulse_strobe();
        check_burst(32'h0F0F_F0F0, -1, -1, "R8 R5");
    endtask

    initial begin
        test_reset();
        test_basic();
        test_rise_no_start();
        test_input_change();
        test_busy_ignore();
        test_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule